// File: doc/BRIEF.md
# Buffered Serial Channel Controller

This block is the host-facing buffering and control layer of one channel in a two-channel serial controller. It sits between a byte-wide host register bus and a bit-level serialiser/deserialiser pair, which are not part of it, and neither is the baud-rate divider. Incoming characters from the deserialiser land in a small receive queue. Outgoing characters pass through a one-character holding stage, so the host can load the next character while the serialiser is still shifting the previous one.

Two mode registers share a single bus address. An internal pointer picks which one a write lands in, and a command field can return that pointer to the first register. The command register also enables, disables and resets the receiver and the transmitter. A clock-select register hands separate receive and transmit rate codes to the divider. Hardware flow control works in both directions. The ready-to-send line can follow the fill level of the receive queue. The clear-to-send line can hold back the transmitter.

Top module: `ser_chan_core`

## Requirements
- R1: After reset the status byte reads 0x00, rts_n is 1, tx_load is 0 and the mode address reads 0x00.
- R2: Writes to address 0 go to mode register 1 first and to mode register 2 every time after that. A command write with bits 6:4 = 001 returns the pointer to mode register 1. A read of address 0 returns the register the pointer selects.
- R3: A write to address 1 puts bits 3:0 on tx_rate and bits 7:4 on rx_rate.
- R4: In a command write (address 2), bits 1:0 = 01 enable the receiver and 10 disable it, and bits 3:2 do the same for the transmitter. So 0x05 enables both and 0x0A disables both. A disabled receiver ignores rx_valid. A disabled transmitter shows TxRDY = 0 and ignores data writes.
- R5: The receive queue holds 4 characters and returns them in arrival order on reads of address 3. A read of an empty queue returns 0x00. Status bit 0 (RxRDY) is set while at least one character waits, and bit 1 (FFULL) is set while all 4 slots are full.
- R6: A character that arrives while the queue is full is discarded and sets status bit 4 (overrun). The flag stays set until command bits 6:4 = 100 or a receiver reset.
- R7: A data write (address 3) is accepted only while the holding stage is empty. The held character goes to the serialiser as a one-cycle tx_load pulse, with the character on tx_data, once tx_busy is low. Status bit 2 (TxRDY) means the holding stage is empty. Status bit 3 (TxEMT) means nothing is held, loading or shifting.
- R8: With mode register 2 bit 4 set, cts_n = 1 prevents any tx_load, and the held character waits until cts_n = 0.
- R9: Bit 0 of the output-port register (address 4) drives rts_n inverted. With mode register 1 bit 7 set, rts_n is also forced to 1 while the receive queue is full, and it returns low once a character has been read.
- R10: Command bits 6:4 = 010 empty the receive queue, clear overrun and break, and disable the receiver. Command bits 6:4 = 011 drop the held character and disable the transmitter.
- R11: A character that arrives with rx_break high sets status bit 7. The bit stays set until command bits 6:4 = 100.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Host write strobe |
| bus_rd | input | 1 | Host read strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid the cycle after bus_rd |
| rx_valid | input | 1 | Deserialiser delivers a character |
| rx_data | input | 8 | Received character |
| rx_break | input | 1 | Character was a break |
| tx_load | output | 1 | One-cycle pulse handing a character to the serialiser |
| tx_data | output | 8 | Character for the serialiser |
| tx_busy | input | 1 | Serialiser is shifting |
| cts_n | input | 1 | Clear-to-send, active low |
| rts_n | output | 1 | Ready-to-send, active low |
| mode1 | output | 8 | Mode register 1 |
| mode2 | output | 8 | Mode register 2 |
| rx_rate | output | 4 | Receive rate code |
| tx_rate | output | 4 | Transmit rate code |

## Verification
Every register write and every accepted rx_valid takes effect at the clock edge that samples it. A read returns bus_rdata after that same edge, so the bench drives at the falling edge and reads the result one falling edge later. tx_load appears one edge after the holding stage fills, provided tx_busy is low. rts_n follows the output-port bit or the queue-full state one edge after they change, so the bench waits one more falling edge before it checks either. The random phase pushes and pops characters one operation at a time and compares each popped byte and each status byte with a queue model in the bench.

// File: rtl/ser_chan_pkg.sv
package ser_chan_pkg;
  localparam logic [2:0] A_MODE  = 3'd0;
  localparam logic [2:0] A_CSEL  = 3'd1;
  localparam logic [2:0] A_CMD   = 3'd2;
  localparam logic [2:0] A_DATA  = 3'd3;
  localparam logic [2:0] A_OPORT = 3'd4;

  typedef enum logic [2:0] {
    MISC_NONE    = 3'b000,
    MISC_PTR_RST = 3'b001,
    MISC_RX_RST  = 3'b010,
    MISC_TX_RST  = 3'b011,
    MISC_ERR_RST = 3'b100
  } misc_cmd_e;

  localparam logic [1:0] EN_ON  = 2'b01;
  localparam logic [1:0] EN_OFF = 2'b10;

  localparam int MR1_AUTO_RTS = 7;
  localparam int MR2_CTS_GATE = 4;
endpackage

// File: rtl/ser_chan_rxq.sv
module ser_chan_rxq #(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             flush,
  input  logic             push,
  input  logic [W-1:0]     push_data,
  input  logic             pop,
  output logic [W-1:0]     pop_data,
  output logic [$clog2(DEPTH):0] count,
  output logic             full,
  output logic             nempty
);
  localparam int PW = $clog2(DEPTH);
  localparam logic [PW:0] CNT_MAX = (PW+1)'(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wp, rp;
  logic          do_push, do_pop;

  assign full    = (count == CNT_MAX);
  assign nempty  = (count != '0);
  assign do_push = push & ~full & ~flush;
  assign do_pop  = pop & nempty & ~flush;

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp <= '0; rp <= '0; count <= '0; pop_data <= '0;
    end else begin
      if (pop) pop_data <= nempty ? mem[rp] : '0;
      if (flush) begin
        wp <= '0; rp <= '0; count <= '0;
      end else begin
        if (do_push) wp <= wp + 1'b1;
        if (do_pop)  rp <= rp + 1'b1;
        if (do_push && !do_pop)      count <= count + 1'b1;
        else if (do_pop && !do_push) count <= count - 1'b1;
      end
    end
  end
endmodule

// File: rtl/ser_chan_txhold.sv
module ser_chan_txhold #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         flush,
  input  logic         enable,
  input  logic         wr,
  input  logic [W-1:0] wr_data,
  input  logic         cts_ok,
  input  logic         ser_busy,
  output logic         ld,
  output logic [W-1:0] ld_data,
  output logic         hold_full
);
  logic [W-1:0] hold_q;
  logic         xfer;

  assign xfer = enable & hold_full & ~ser_busy & ~ld & cts_ok;

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_full <= 1'b0; ld <= 1'b0; ld_data <= '0; hold_q <= '0;
    end else if (flush) begin
      hold_full <= 1'b0; ld <= 1'b0;
    end else begin
      ld <= xfer;
      if (xfer) begin
        ld_data   <= hold_q;
        hold_full <= 1'b0;
      end else if (wr && enable && !hold_full) begin
        hold_q    <= wr_data;
        hold_full <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/ser_chan_cfg.sv
module ser_chan_cfg #(
  parameter int W  = 8,
  parameter int RW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          mode_wr,
  input  logic          ptr_rst,
  input  logic          csel_wr,
  input  logic          oport_wr,
  input  logic [W-1:0]  wdata,
  output logic [W-1:0]  mr1,
  output logic [W-1:0]  mr2,
  output logic [W-1:0]  mode_rd,
  output logic [RW-1:0] rx_rate,
  output logic [RW-1:0] tx_rate,
  output logic [W-1:0]  oport
);
  logic ptr_q;

  assign mode_rd = ptr_q ? mr2 : mr1;

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_q <= 1'b0; mr1 <= '0; mr2 <= '0;
      rx_rate <= '0; tx_rate <= '0; oport <= '0;
    end else begin
      if (ptr_rst) begin
        ptr_q <= 1'b0;
      end else if (mode_wr) begin
        if (ptr_q) mr2 <= wdata;
        else       mr1 <= wdata;
        ptr_q <= 1'b1;
      end
      if (csel_wr) begin
        tx_rate <= wdata[RW-1:0];
        rx_rate <= wdata[2*RW-1:RW];
      end
      if (oport_wr) oport <= wdata;
    end
  end
endmodule

// File: rtl/ser_chan_core.sv
module ser_chan_core #(
  parameter int DW     = 8,
  parameter int ADDR_W = 3,
  parameter int DEPTH  = 4,
  parameter int RATE_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  input  logic              rx_valid,
  input  logic [DW-1:0]     rx_data,
  input  logic              rx_break,
  output logic              tx_load,
  output logic [DW-1:0]     tx_data,
  input  logic              tx_busy,
  input  logic              cts_n,
  output logic              rts_n,
  output logic [DW-1:0]     mode1,
  output logic [DW-1:0]     mode2,
  output logic [RATE_W-1:0] rx_rate,
  output logic [RATE_W-1:0] tx_rate
);
  import ser_chan_pkg::*;
  localparam int CW = $clog2(DEPTH) + 1;

  logic wr_mode, wr_csel, wr_cmd, wr_data, wr_oport, rd_data;
  logic rx_en, tx_en, ovr_q, brk_q;
  logic rx_flush, tx_flush, ptr_rst, err_clr;
  logic rx_try, rx_full, rx_nempty, hold_full, cts_ok;
  logic [CW-1:0] rx_cnt;
  logic [DW-1:0] fifo_out, mode_rd, oport, status, reg_rd_q;
  logic          rd_fifo_q;
  misc_cmd_e     misc;

  assign wr_mode  = bus_wr && (bus_addr == ADDR_W'(A_MODE));
  assign wr_csel  = bus_wr && (bus_addr == ADDR_W'(A_CSEL));
  assign wr_cmd   = bus_wr && (bus_addr == ADDR_W'(A_CMD));
  assign wr_data  = bus_wr && (bus_addr == ADDR_W'(A_DATA));
  assign wr_oport = bus_wr && (bus_addr == ADDR_W'(A_OPORT));
  assign rd_data  = bus_rd && (bus_addr == ADDR_W'(A_DATA));

  assign misc     = wr_cmd ? misc_cmd_e'(bus_wdata[6:4]) : MISC_NONE;
  assign ptr_rst  = (misc == MISC_PTR_RST);
  assign rx_flush = (misc == MISC_RX_RST);
  assign tx_flush = (misc == MISC_TX_RST);
  assign err_clr  = (misc == MISC_ERR_RST) || rx_flush;

  assign rx_try = rx_en & rx_valid;
  assign cts_ok = ~(mode2[MR2_CTS_GATE] & cts_n);

  // enables, sticky error flags
  always_ff @(posedge clk) begin
    if (rst) begin
      rx_en <= 1'b0; tx_en <= 1'b0; ovr_q <= 1'b0; brk_q <= 1'b0;
    end else begin
      if (wr_cmd) begin
        if (bus_wdata[1:0] == EN_ON)  rx_en <= 1'b1;
        if (bus_wdata[1:0] == EN_OFF) rx_en <= 1'b0;
        if (bus_wdata[3:2] == EN_ON)  tx_en <= 1'b1;
        if (bus_wdata[3:2] == EN_OFF) tx_en <= 1'b0;
        if (rx_flush) rx_en <= 1'b0;
        if (tx_flush) tx_en <= 1'b0;
      end
      if (err_clr) begin
        ovr_q <= 1'b0; brk_q <= 1'b0;
      end else begin
        if (rx_try && rx_full)  ovr_q <= 1'b1;
        if (rx_try && rx_break) brk_q <= 1'b1;
      end
    end
  end

  ser_chan_rxq #(.W(DW), .DEPTH(DEPTH)) u_rxq (
    .clk(clk), .rst(rst), .flush(rx_flush), .push(rx_try), .push_data(rx_data),
    .pop(rd_data), .pop_data(fifo_out), .count(rx_cnt), .full(rx_full), .nempty(rx_nempty)
  );

  ser_chan_txhold #(.W(DW)) u_tx (
    .clk(clk), .rst(rst), .flush(tx_flush), .enable(tx_en), .wr(wr_data),
    .wr_data(bus_wdata), .cts_ok(cts_ok), .ser_busy(tx_busy),
    .ld(tx_load), .ld_data(tx_data), .hold_full(hold_full)
  );

  ser_chan_cfg #(.W(DW), .RW(RATE_W)) u_cfg (
    .clk(clk), .rst(rst), .mode_wr(wr_mode), .ptr_rst(ptr_rst), .csel_wr(wr_csel),
    .oport_wr(wr_oport), .wdata(bus_wdata), .mr1(mode1), .mr2(mode2), .mode_rd(mode_rd),
    .rx_rate(rx_rate), .tx_rate(tx_rate), .oport(oport)
  );

  always_comb begin
    status    = '0;
    status[0] = rx_nempty;
    status[1] = rx_full;
    status[2] = tx_en & ~hold_full;
    status[3] = tx_en & ~hold_full & ~tx_busy & ~tx_load;
    status[4] = ovr_q;
    status[7] = brk_q;
  end

  // registered read path and flow-control output
  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rd_q <= '0; rd_fifo_q <= 1'b0; rts_n <= 1'b1;
    end else begin
      rts_n <= ~(oport[0] & ~(mode1[MR1_AUTO_RTS] & rx_full));
      if (bus_rd) begin
        rd_fifo_q <= rd_data;
        case (bus_addr)
          ADDR_W'(A_MODE):  reg_rd_q <= mode_rd;
          ADDR_W'(A_CSEL):  reg_rd_q <= status;
          ADDR_W'(A_OPORT): reg_rd_q <= oport;
          default:          reg_rd_q <= '0;
        endcase
      end
    end
  end

  assign bus_rdata = rd_fifo_q ? fifo_out : reg_rd_q;
endmodule

// File: rtl/ser_chan_chk.sv
module ser_chan_chk #(
  parameter int DEPTH = 4,
  parameter int CW    = 3
) (
  input logic          clk,
  input logic          rst,
  input logic [CW-1:0] rx_cnt,
  input logic          rx_nempty,
  input logic          rx_flush,
  input logic          ovr_q,
  input logic          err_clr,
  input logic          tx_load,
  input logic          cts_n,
  input logic          cts_gate,
  input logic          rts_n,
  input logic          rts_auto,
  input logic          rx_full
);
  a_r5_cnt_bound: assert property (@(posedge clk) disable iff (rst)
    rx_cnt <= CW'(DEPTH));
  a_r6_ovr_sticky: assert property (@(posedge clk) disable iff (rst)
    (ovr_q && !err_clr) |=> ovr_q);
  a_r7_single_load: assert property (@(posedge clk) disable iff (rst)
    tx_load |=> !tx_load);
  a_r8_cts_gate: assert property (@(posedge clk) disable iff (rst)
    (cts_gate && cts_n) |=> !tx_load);
  a_r9_rts_full: assert property (@(posedge clk) disable iff (rst)
    (rts_auto && rx_full) |=> rts_n);
  a_r10_flush_empty: assert property (@(posedge clk) disable iff (rst)
    rx_flush |=> !rx_nempty);
endmodule

bind ser_chan_core ser_chan_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
  .clk(clk), .rst(rst), .rx_cnt(rx_cnt), .rx_nempty(rx_nempty), .rx_flush(rx_flush),
  .ovr_q(ovr_q), .err_clr(err_clr), .tx_load(tx_load), .cts_n(cts_n),
  .cts_gate(mode2[4]), .rts_n(rts_n), .rts_auto(mode1[7]), .rx_full(rx_full)
);

// File: tb/sim_ser_chan_core.sv
`timescale 1ns/1ps
module sim_ser_chan_core;
  localparam int BUSY_LEN = 20;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bus_wr = 0, bus_rd = 0;
  logic [2:0] bus_addr = 0;
  logic [7:0] bus_wdata = 0, bus_rdata;
  logic rx_valid = 0, rx_break = 0;
  logic [7:0] rx_data = 0;
  logic tx_load, tx_busy, rts_n;
  logic cts_n = 0;
  logic [7:0] tx_data, mode1, mode2;
  logic [3:0] rx_rate, tx_rate;

  int total = 0, bad = 0;
  int busy_cnt = 0;
  bit done = 0;
  logic [7:0] txlog[$];
  logic [7:0] model[$];

  always #4 clk = ~clk;

  ser_chan_core u0 (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_break(rx_break), .tx_load(tx_load), .tx_data(tx_data), .tx_busy(tx_busy),
    .cts_n(cts_n), .rts_n(rts_n), .mode1(mode1), .mode2(mode2),
    .rx_rate(rx_rate), .tx_rate(tx_rate)
  );

  // serialiser stand-in: busy for BUSY_LEN cycles after each load
  assign tx_busy = (busy_cnt != 0);
  always @(posedge clk) begin
    if (rst) busy_cnt <= 0;
    else if (tx_load) busy_cnt <= BUSY_LEN;
    else if (busy_cnt != 0) busy_cnt <= busy_cnt - 1;
    if (!rst && tx_load) txlog.push_back(tx_data);
  end

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); bus_rd = 1; bus_addr = a;
    @(negedge clk); bus_rd = 0; d = bus_rdata;
  endtask

  task automatic rx(input logic [7:0] d, input logic b);
    @(negedge clk); rx_valid = 1; rx_data = d; rx_break = b;
    @(negedge clk); rx_valid = 0; rx_break = 0;
  endtask

  function automatic logic [7:0] exp_stat(input int n, input bit ovr, input bit brk,
                                          input bit trdy, input bit temt);
    return {brk, 2'b00, ovr, temt, trdy, (n == 4), (n != 0)};
  endfunction

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : main
    logic [7:0] v;
    bit ovr_m;
    int n0;
    void'($urandom(32'd2024));
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);

    // R1 reset state
    rd(3'd1, v); chk("R1 status", v, 8'h00);
    chk("R1 rts_n", rts_n, 1);
    chk("R1 tx_load", tx_load, 0);
    rd(3'd0, v); chk("R1 mode", v, 8'h00);

    // R2 mode pointer
    wr(3'd0, 8'h93); wr(3'd0, 8'h17);
    chk("R2 mr1", mode1, 8'h93); chk("R2 mr2", mode2, 8'h17);
    rd(3'd0, v); chk("R2 read mr2", v, 8'h17);
    wr(3'd0, 8'h55);
    chk("R2 mr2 again", mode2, 8'h55); chk("R2 mr1 kept", mode1, 8'h93);
    wr(3'd2, 8'h10);
    rd(3'd0, v); chk("R2 ptr reset", v, 8'h93);

    // R3 clock select
    wr(3'd1, 8'hB8);
    chk("R3 rx_rate", rx_rate, 4'hB); chk("R3 tx_rate", tx_rate, 4'h8);
    wr(3'd1, 8'hBB);
    chk("R3 tx_rate both", tx_rate, 4'hB);

    // R4 disabled receiver ignores input, then enable both
    rx(8'h41, 0);
    rd(3'd1, v); chk("R4 rx disabled", v, 8'h00);
    wr(3'd2, 8'h05);
    rd(3'd1, v); chk("R4 enabled", v, 8'h0C);

    // R5 R6 random push/pop against a queue model
    ovr_m = 0;
    for (int i = 0; i < 300; i++) begin
      int op;
      op = $urandom_range(0, 2);
      if (op != 0) begin
        logic [7:0] d;
        d = 8'($urandom);
        rx(d, 0);
        if (model.size() < 4) model.push_back(d); else ovr_m = 1;
      end else begin
        logic [7:0] e;
        e = (model.size() != 0) ? model.pop_front() : 8'h00;
        rd(3'd3, v); chk("R5 pop data", v, e);
      end
      rd(3'd1, v); chk("R5 R6 status", v, exp_stat(model.size(), ovr_m, 0, 1, 1));
    end
    // R6 directed overrun, then clear
    while (model.size() < 4) begin model.push_back(8'h60); rx(8'h60, 0); end
    rx(8'hEE, 0);
    rd(3'd1, v); chk("R6 overrun set", v, exp_stat(4, 1, 0, 1, 1));
    wr(3'd2, 8'h40);
    rd(3'd1, v); chk("R6 overrun clear", v, exp_stat(4, 0, 0, 1, 1));
    while (model.size() != 0) begin
      logic [7:0] e;
      e = model.pop_front();
      rd(3'd3, v); chk("R5 drain order", v, e);
    end
    rd(3'd3, v); chk("R5 empty read", v, 8'h00);

    // R11 break
    rx(8'h00, 1);
    rd(3'd1, v); chk("R11 break set", v[7], 1);
    rd(3'd3, v);
    wr(3'd2, 8'h40);
    rd(3'd1, v); chk("R11 break clear", v, 8'h0C);

    // R7 double-buffered transmit
    txlog.delete();
    wr(3'd2, 8'h10); wr(3'd0, 8'h80); wr(3'd0, 8'h00);
    wr(3'd3, 8'hA5);
    @(negedge clk);
    chk("R7 load pulse", tx_load, 1); chk("R7 load data", tx_data, 8'hA5);
    wr(3'd3, 8'h3C); wr(3'd3, 8'h77);
    rd(3'd1, v); chk("R7 held status", v & 8'h0C, 8'h00);
    repeat (60) @(negedge clk);
    chk("R7 load count", txlog.size(), 2);
    if (txlog.size() == 2) chk("R7 second char", txlog[1], 8'h3C);
    rd(3'd1, v); chk("R7 idle status", v & 8'h0C, 8'h0C);

    // R8 CTS gating
    wr(3'd2, 8'h10); wr(3'd0, 8'h80); wr(3'd0, 8'h10);
    cts_n = 1;
    wr(3'd3, 8'h5A);
    repeat (40) @(negedge clk);
    chk("R8 blocked", txlog.size(), 2);
    rd(3'd1, v); chk("R8 held", v & 8'h0C, 8'h00);
    cts_n = 0;
    repeat (3) @(negedge clk);
    chk("R8 released", txlog.size(), 3);
    if (txlog.size() == 3) chk("R8 char", txlog[2], 8'h5A);
    repeat (30) @(negedge clk);

    // R9 RTS control
    wr(3'd4, 8'h01); @(negedge clk);
    chk("R9 software assert", rts_n, 0);
    for (int k = 0; k < 3; k++) rx(8'(8'h20 + k), 0);
    @(negedge clk); chk("R9 three held", rts_n, 0);
    rx(8'h23, 0);
    @(negedge clk); chk("R9 full negates", rts_n, 1);
    rd(3'd3, v); chk("R9 pop data", v, 8'h20);
    @(negedge clk); chk("R9 room asserts", rts_n, 0);
    wr(3'd4, 8'h00); @(negedge clk);
    chk("R9 software negate", rts_n, 1);

    // R10 receiver reset
    wr(3'd2, 8'h20);
    rd(3'd1, v); chk("R10 rx flushed", v & 8'h13, 8'h00);
    rx(8'h44, 0);
    rd(3'd1, v); chk("R10 rx disabled", v[0], 0);

    // R10 transmitter reset drops held char
    n0 = txlog.size();
    cts_n = 1;
    wr(3'd3, 8'h99);
    wr(3'd2, 8'h30);
    rd(3'd1, v); chk("R10 tx disabled", v & 8'h0C, 8'h00);
    wr(3'd2, 8'h04);
    cts_n = 0;
    repeat (10) @(negedge clk);
    chk("R10 char dropped", txlog.size(), n0);
    rd(3'd1, v); chk("R10 tx empty", v & 8'h0C, 8'h0C);

    // R4 disable both
    wr(3'd2, 8'h0A);
    rd(3'd1, v); chk("R4 disabled", v & 8'h0C, 8'h00);
    wr(3'd3, 8'h11);
    repeat (5) @(negedge clk);
    chk("R4 tx write ignored", txlog.size(), n0);
    rx(8'h12, 0);
    rd(3'd1, v); chk("R4 rx ignored", v[0], 0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule